// File: doc/BRIEF.md
# LIN slave frame data controller

This block runs the data field of a LIN frame on a slave node once the header has been taken off the bus. Break and sync detection, baud recovery and identifier parity checking sit outside the block. They arrive here as a one-cycle header strobe that carries the protected identifier and a parity-good flag. A byte-level serial engine sits on the other side. The block asks it to send bytes, and the engine reports bytes it has sent or received, along with bit and framing errors.

Software sees a valid header through an identifier interrupt. It then writes one setting per frame: the data length (1 to 8 bytes), the direction, and the checksum mode (classic or enhanced). The block counts the data bytes and keeps a running checksum. It either sends that checksum after the data or compares it with the received checksum byte. On completion, error or abort it raises a cause-coded one-cycle interrupt.

Two controls reduce software involvement. A transmit abort lets the byte currently on the wire finish and then stops the frame; the abort bit clears itself. An ignore-frame control silences all interrupts until the next header. While a frame is ignored, incoming bytes are still written into the message buffer.

Top module: `lin_frame_data`

## Requirements
- R1: A header strobe with parity good raises `irq` one cycle later with `irqCause` = 1 (identifier), clears all error flags and opens the frame. A header strobe with parity bad raises no interrupt, and a following setting write is rejected.
- R2: A setting write while the frame waits for its setting, with `cfgLen` from 1 to 8, loads the length, the direction (`cfgTx` = 1 transmits) and the checksum mode (`cfgEnhanced` = 1 enhanced).
- R3: A setting write at any other time, or with length 0 or above 8, sets `errMisuse`. It changes neither the length, the direction nor the running count.
- R4: When receiving, data bytes go to buffer entries 0 to length-1 in order and are readable on `rdData` at `rdAddr`. The next byte is taken as the checksum. If it matches, `irq` is raised with `irqCause` = 2 (done).
- R5: The checksum is an 8-bit sum with end-around carry, inverted at the end. Classic mode sums the data bytes only; enhanced mode starts from the protected identifier. A received checksum that differs sets `errChecksum` and raises `irqCause` = 3 (error).
- R6: When transmitting, `txReq` stays high and `txByte` shows buffer entry 0 up to length-1 and then the checksum, advancing on each `txDone`. After the checksum byte completes, `txReq` drops and `irqCause` = 2 is raised.
- R7: An abort written while transmitting keeps `txReq` and `txByte` unchanged until the current byte's `txDone`. Nothing further is then sent, `abortPend` returns to 0 and `irqCause` = 4 (aborted) is raised.
- R8: An abort written while not transmitting has no effect, and `abortPend` reads 0.
- R9: After the ignore control is written, no interrupt is raised until the next valid header. `ignorePend` returns to 0 when the bus goes idle.
- R10: In an ignored frame, received data bytes still overwrite the buffer, and a checksum mismatch still sets `errChecksum`.
- R11: A received byte with a framing error sets `errFrame`. A transmitted byte with a bit error sets `errBit`. Either one ends the frame with `irqCause` = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hdrValid | input | 1 | One-cycle strobe: header received |
| hdrParityOk | input | 1 | Identifier parity passed, valid with hdrValid |
| hdrPid | input | 8 | Protected identifier, valid with hdrValid |
| busIdle | input | 1 | Bus has returned to idle |
| cfgWr | input | 1 | Write the per-frame setting |
| cfgLen | input | LEN_W | Data length in bytes |
| cfgEnhanced | input | 1 | 1 = enhanced checksum, 0 = classic |
| cfgTx | input | 1 | 1 = node transmits the data field |
| abortWr | input | 1 | Request transmit abort |
| ignoreWr | input | 1 | Request ignore of the current frame |
| bufWr | input | 1 | Software write into the message buffer |
| bufAddr | input | PTR_W | Buffer write index |
| bufWdata | input | 8 | Buffer write data |
| rdAddr | input | PTR_W | Buffer read index |
| rdData | output | 8 | Buffer read data |
| rxValid | input | 1 | Serial engine received a byte |
| rxByte | input | 8 | Received byte |
| rxFrameErr | input | 1 | Stop-bit error on the received byte |
| txReq | output | 1 | Request to send txByte |
| txByte | output | 8 | Byte to send |
| txDone | input | 1 | Current transmit byte finished |
| txBitErr | input | 1 | Readback mismatch on the finished byte |
| irq | output | 1 | One-cycle interrupt pulse |
| irqCause | output | 3 | 1 identifier, 2 done, 3 error, 4 aborted |
| abortPend | output | 1 | Abort bit |
| ignorePend | output | 1 | Ignore bit |
| errFrame | output | 1 | Framing error flag |
| errChecksum | output | 1 | Checksum error flag |
| errBit | output | 1 | Bit error flag |
| errMisuse | output | 1 | Setting written more than once or out of turn |

## Verification
On every cycle, the assertions check the following. The abort bit exists only while transmitting, and it is gone after the byte that honours it. A transmit request is never withdrawn before its byte completes. No interrupt leaves the block while a frame is ignored. Every interrupt carries a cause. Data is never stored at or past the checksum position, and the length changes only on an accepted setting.

The checksum values, the buffer contents and the rule that a repeated setting write does not restart the count can only be shown by the bench. It sweeps every length in both checksum modes in both directions, and then drives the misuse, abort, ignore and error scenarios.

// File: rtl/lin_fd_pkg.sv
package lin_fd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR  = 3'd1,
    ST_RX   = 3'd2,
    ST_TX   = 3'd3,
    ST_DONE = 3'd4
  } fdState_e;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_ID    = 3'd1,
    CAUSE_DONE  = 3'd2,
    CAUSE_ERR   = 3'd3,
    CAUSE_ABORT = 3'd4
  } irqCause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchHdr;   // capture identifier, rewind pointer
    logic loadCfg;    // take length and seed checksum
    logic storeRaw;   // store byte with no length (frame not set up)
    logic storeRx;    // store data byte and accumulate
    logic advTx;      // accumulate sent byte and advance
  } dpCtl_t;

  function automatic logic [7:0] addCarry(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

endpackage

// File: rtl/lin_fd_datapath.sv
module lin_fd_datapath
  import lin_fd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [7:0]       hdrPid,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgEnhanced,
  input  logic [7:0]       rxByte,
  input  logic             bufWr,
  input  logic [PTR_W-1:0] bufAddr,
  input  logic [7:0]       bufWdata,
  input  logic [PTR_W-1:0] rdAddr,
  output logic [7:0]       rdData,
  output logic [7:0]       txByte,
  output logic             atChecksum,
  output logic             sumOk
);

  logic [7:0]       bufQ [DEPTH];
  logic [LEN_W-1:0] ptrQ;
  logic [LEN_W-1:0] lenQ;
  logic [7:0]       sumQ;
  logic [7:0]       pidQ;
  logic [PTR_W-1:0] idx;
  logic             rxWrite;

  assign idx        = ptrQ[PTR_W-1:0];
  assign rxWrite    = ctl.storeRx | ctl.storeRaw;
  assign atChecksum = (ptrQ == lenQ);
  assign sumOk      = (rxByte == ~sumQ);
  assign txByte     = atChecksum ? ~sumQ : bufQ[idx];
  assign rdData     = bufQ[rdAddr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufQ[i] <= 8'd0;
      end else if (rxWrite && idx == PTR_W'(i)) begin
        bufQ[i] <= rxByte;
      end else if (bufWr && bufAddr == PTR_W'(i)) begin
        bufQ[i] <= bufWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      lenQ <= '0;
      sumQ <= 8'd0;
      pidQ <= 8'd0;
    end else begin
      if (ctl.latchHdr) begin
        ptrQ <= '0;
        pidQ <= hdrPid;
      end else if (ctl.loadCfg) begin
        ptrQ <= '0;
        lenQ <= cfgLen;
        sumQ <= cfgEnhanced ? pidQ : 8'd0;
      end else if (ctl.storeRaw) begin
        ptrQ <= (int'(ptrQ) == DEPTH - 1) ? '0 : ptrQ + LEN_W'(1);
      end else if (ctl.storeRx) begin
        ptrQ <= ptrQ + LEN_W'(1);
        sumQ <= addCarry(sumQ, rxByte);
      end else if (ctl.advTx) begin
        ptrQ <= ptrQ + LEN_W'(1);
        sumQ <= addCarry(sumQ, txByte);
      end
    end
  end

  // R4: data is never stored at or past the checksum position
  p_store_in_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.storeRx |-> (ptrQ < lenQ));

  // R3: length changes only on an accepted setting
  p_len_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadCfg |=> $stable(lenQ));

endmodule

// File: rtl/lin_fd_control.sv
module lin_fd_control
  import lin_fd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hdrValid,
  input  logic             hdrParityOk,
  input  logic             busIdle,
  input  logic             cfgWr,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgTx,
  input  logic             abortWr,
  input  logic             ignoreWr,
  input  logic             rxValid,
  input  logic             rxFrameErr,
  input  logic             txDone,
  input  logic             txBitErr,
  input  logic             atChecksum,
  input  logic             sumOk,
  output dpCtl_t           ctl,
  output logic             txReq,
  output logic             irq,
  output logic [2:0]       irqCause,
  output logic             abortPend,
  output logic             ignorePend,
  output logic             errFrame,
  output logic             errChecksum,
  output logic             errBit,
  output logic             errMisuse
);

  fdState_e  stQ, stN;
  irqCause_e cause;
  logic      abortQ, abortN;
  logic      ignQ, ignN;
  logic      lenOk, clrFlags;
  logic      setFr, setCk, setBt, setMu;
  logic      irqN;

  assign lenOk = (cfgLen != '0) && (int'(cfgLen) <= DEPTH);

  always_comb begin
    stN      = stQ;
    ctl      = '0;
    cause    = CAUSE_NONE;
    abortN   = abortQ;
    ignN     = ignQ;
    clrFlags = 1'b0;
    setFr    = 1'b0;
    setCk    = 1'b0;
    setBt    = 1'b0;
    setMu    = 1'b0;

    if (abortWr && stQ == ST_TX) abortN = 1'b1;
    if (ignoreWr && stQ != ST_IDLE) ignN = 1'b1;

    if (cfgWr) begin
      if (stQ == ST_HDR && lenOk) begin
        ctl.loadCfg = 1'b1;
        stN = cfgTx ? ST_TX : ST_RX;
      end else begin
        setMu = 1'b1;
      end
    end

    unique case (stQ)
      ST_HDR: begin
        if (rxValid && !rxFrameErr && !cfgWr) ctl.storeRaw = 1'b1;
      end
      ST_RX: begin
        if (rxValid) begin
          if (rxFrameErr) begin
            setFr = 1'b1;
            cause = CAUSE_ERR;
            stN   = ST_DONE;
          end else if (atChecksum) begin
            if (sumOk) begin
              cause = CAUSE_DONE;
            end else begin
              setCk = 1'b1;
              cause = CAUSE_ERR;
            end
            stN = ST_DONE;
          end else begin
            ctl.storeRx = 1'b1;
          end
        end
      end
      ST_TX: begin
        if (txDone) begin
          if (txBitErr) begin
            setBt = 1'b1;
            cause = CAUSE_ERR;
            stN   = ST_DONE;
          end else if (atChecksum) begin
            cause = CAUSE_DONE;
            stN   = ST_DONE;
          end else begin
            ctl.advTx = 1'b1;
            if (abortQ) begin
              cause = CAUSE_ABORT;
              stN   = ST_DONE;
            end
          end
        end
      end
      default: ;
    endcase

    if (busIdle && stQ != ST_IDLE) begin
      stN  = ST_IDLE;
      ignN = 1'b0;
    end

    if (hdrValid) begin
      ctl          = '0;
      ctl.latchHdr = 1'b1;
      clrFlags     = 1'b1;
      ignN         = 1'b0;
      setFr        = 1'b0;
      setCk        = 1'b0;
      setBt        = 1'b0;
      setMu        = 1'b0;
      if (hdrParityOk) begin
        stN   = ST_HDR;
        cause = CAUSE_ID;
      end else begin
        stN   = ST_IDLE;
        cause = CAUSE_NONE;
      end
    end

    if (stN != ST_TX) abortN = 1'b0;

    irqN = (cause != CAUSE_NONE) && (cause == CAUSE_ID || !ignQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ         <= ST_IDLE;
      abortQ      <= 1'b0;
      ignQ        <= 1'b0;
      irq         <= 1'b0;
      irqCause    <= 3'd0;
      errFrame    <= 1'b0;
      errChecksum <= 1'b0;
      errBit      <= 1'b0;
      errMisuse   <= 1'b0;
    end else begin
      stQ      <= stN;
      abortQ   <= abortN;
      ignQ     <= ignN;
      irq      <= irqN;
      irqCause <= irqN ? cause : CAUSE_NONE;
      if (clrFlags) begin
        errFrame    <= 1'b0;
        errChecksum <= 1'b0;
        errBit      <= 1'b0;
        errMisuse   <= 1'b0;
      end else begin
        errFrame    <= errFrame    | setFr;
        errChecksum <= errChecksum | setCk;
        errBit      <= errBit      | setBt;
        errMisuse   <= errMisuse   | setMu;
      end
    end
  end

  assign txReq      = (stQ == ST_TX);
  assign abortPend  = abortQ;
  assign ignorePend = ignQ;

  // R8: the abort bit can only be held while a byte is being sent
  p_abort_only_tx_r8: assert property (@(posedge clk) disable iff (!rstN)
    abortPend |-> txReq);

  // R7: the byte that honours an abort also clears it
  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (abortPend && txDone && !hdrValid) |=> !abortPend);

  // R7: a request is not withdrawn before its byte completes
  p_txreq_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !txDone && !hdrValid && !busIdle) |=> txReq);

  // R9: an ignored frame stays silent
  p_ignore_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ignorePend && !hdrValid) |=> !irq);

  // R1: every interrupt names its cause
  p_irq_cause_r1: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqCause != 3'd0));

endmodule

// File: rtl/lin_frame_data.sv
module lin_frame_data
  import lin_fd_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hdrValid,
  input  logic             hdrParityOk,
  input  logic [7:0]       hdrPid,
  input  logic             busIdle,
  input  logic             cfgWr,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgEnhanced,
  input  logic             cfgTx,
  input  logic             abortWr,
  input  logic             ignoreWr,
  input  logic             bufWr,
  input  logic [PTR_W-1:0] bufAddr,
  input  logic [7:0]       bufWdata,
  input  logic [PTR_W-1:0] rdAddr,
  output logic [7:0]       rdData,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  input  logic             rxFrameErr,
  output logic             txReq,
  output logic [7:0]       txByte,
  input  logic             txDone,
  input  logic             txBitErr,
  output logic             irq,
  output logic [2:0]       irqCause,
  output logic             abortPend,
  output logic             ignorePend,
  output logic             errFrame,
  output logic             errChecksum,
  output logic             errBit,
  output logic             errMisuse
);

  dpCtl_t ctl;
  logic   atChecksum;
  logic   sumOk;

  lin_fd_control #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hdrValid(hdrValid), .hdrParityOk(hdrParityOk), .busIdle(busIdle),
    .cfgWr(cfgWr), .cfgLen(cfgLen), .cfgTx(cfgTx),
    .abortWr(abortWr), .ignoreWr(ignoreWr),
    .rxValid(rxValid), .rxFrameErr(rxFrameErr),
    .txDone(txDone), .txBitErr(txBitErr),
    .atChecksum(atChecksum), .sumOk(sumOk),
    .ctl(ctl), .txReq(txReq), .irq(irq), .irqCause(irqCause),
    .abortPend(abortPend), .ignorePend(ignorePend),
    .errFrame(errFrame), .errChecksum(errChecksum),
    .errBit(errBit), .errMisuse(errMisuse)
  );

  lin_fd_datapath #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .hdrPid(hdrPid), .cfgLen(cfgLen), .cfgEnhanced(cfgEnhanced),
    .rxByte(rxByte),
    .bufWr(bufWr), .bufAddr(bufAddr), .bufWdata(bufWdata),
    .rdAddr(rdAddr), .rdData(rdData),
    .txByte(txByte), .atChecksum(atChecksum), .sumOk(sumOk)
  );

endmodule

// File: tb/sim_lin_frame_data.sv
module sim_lin_frame_data;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdrValid = 0, hdrParityOk = 0, busIdle = 0;
  logic [7:0] hdrPid = 0;
  logic cfgWr = 0, cfgEnhanced = 0, cfgTx = 0;
  logic [3:0] cfgLen = 0;
  logic abortWr = 0, ignoreWr = 0, bufWr = 0;
  logic [2:0] bufAddr = 0, rdAddr = 0;
  logic [7:0] bufWdata = 0, rxByte = 0;
  logic rxValid = 0, rxFrameErr = 0, txDone = 0, txBitErr = 0;
  logic [7:0] rdData, txByte;
  logic txReq, irq, abortPend, ignorePend;
  logic errFrame, errChecksum, errBit, errMisuse;
  logic [2:0] irqCause;

  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_frame_data #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkIrq(input string tag, input int expCause);
    chk((expCause == 0) ? (irq == 1'b0) : (irq == 1'b1 && irqCause == 3'(expCause)),
        tag, irq ? int'(irqCause) : 0, expCause);
  endtask

  function automatic logic [7:0] dat(input int len, input int enh, input int i);
    return 8'((len * 37 + i * 91 + enh * 5 + 200) & 255);
  endfunction

  function automatic logic [7:0] csum(input int enh, input logic [7:0] pid,
                                     input int len, input int base);
    logic [8:0] s;
    s = enh ? {1'b0, pid} : 9'd0;
    for (int i = 0; i < len; i++) begin
      s = {1'b0, s[7:0]} + {1'b0, dat(base, enh, i)};
      s = {1'b0, s[7:0] + {7'd0, s[8]}};
    end
    return ~s[7:0];
  endfunction

  task automatic header(input logic [7:0] pid, input bit par);
    @(negedge clk); hdrValid = 1; hdrPid = pid; hdrParityOk = par;
    @(negedge clk); hdrValid = 0;
  endtask

  task automatic setup(input int len, input bit enh, input bit tx);
    @(negedge clk); cfgWr = 1; cfgLen = 4'(len); cfgEnhanced = enh; cfgTx = tx;
    @(negedge clk); cfgWr = 0;
  endtask

  task automatic rxb(input logic [7:0] b, input bit ferr);
    @(negedge clk); rxValid = 1; rxByte = b; rxFrameErr = ferr;
    @(negedge clk); rxValid = 0; rxFrameErr = 0;
  endtask

  task automatic txd(input bit berr);
    @(negedge clk); txDone = 1; txBitErr = berr;
    @(negedge clk); txDone = 0; txBitErr = 0;
  endtask

  task automatic idle();
    @(negedge clk); busIdle = 1;
    @(negedge clk); busIdle = 0;
  endtask

  task automatic pulseAbort();
    @(negedge clk); abortWr = 1;
    @(negedge clk); abortWr = 0;
  endtask

  task automatic pulseIgnore();
    @(negedge clk); ignoreWr = 1;
    @(negedge clk); ignoreWr = 0;
  endtask

  task automatic swWrite(input int a, input logic [7:0] d);
    @(negedge clk); bufWr = 1; bufAddr = 3'(a); bufWdata = d;
    @(negedge clk); bufWr = 0;
  endtask

  task automatic readChk(input int a, input logic [7:0] exp, input string tag);
    rdAddr = 3'(a); #1;
    chk(rdData == exp, tag, rdData, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic [7:0] pid, ck;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!irq && !txReq && !abortPend && !ignorePend, "reset outputs", irq, 0);
    chk(!errFrame && !errChecksum && !errBit && !errMisuse, "reset flags", 0, 0);

    // R4 R5 R2: receive sweep, all lengths, both modes
    for (int enh = 0; enh < 2; enh++) begin
      for (int len = 1; len <= DEPTH; len++) begin
        pid = 8'(len * 29 + enh * 97 + 3);
        header(pid, 1);
        chkIrq("R1 id irq rx", 1);
        setup(len, enh[0], 0);
        for (int i = 0; i < len; i++) begin
          rxb(dat(len, enh, i), 0);
          chkIrq("R4 no irq mid frame", 0);
        end
        rxb(csum(enh, pid, len, len), 0);
        chkIrq("R5 R4 checksum accepted", 2);
        chk(!errChecksum, "R5 no checksum flag", errChecksum, 0);
        for (int i = 0; i < len; i++) readChk(i, dat(len, enh, i), "R4 buffer content");
        idle();
      end
    end

    // R6 R5: transmit sweep
    for (int enh = 0; enh < 2; enh++) begin
      for (int len = 1; len <= DEPTH; len++) begin
        pid = 8'(len * 53 + enh * 11 + 130);
        for (int i = 0; i < len; i++) swWrite(i, dat(len, enh, i));
        header(pid, 1);
        chkIrq("R1 id irq tx", 1);
        setup(len, enh[0], 1);
        for (int i = 0; i < len; i++) begin
          chk(txReq && txByte == dat(len, enh, i), "R6 tx data byte", txByte, dat(len, enh, i));
          txd(0);
          chkIrq("R6 no irq mid tx", 0);
        end
        ck = csum(enh, pid, len, len);
        chk(txReq && txByte == ck, "R6 R5 tx checksum", txByte, ck);
        txd(0);
        chkIrq("R6 tx done irq", 2);
        chk(!txReq, "R6 txReq drops", txReq, 0);
        idle();
      end
    end

    // R5: wrong checksum
    header(8'h42, 1);
    setup(3, 1, 0);
    for (int i = 0; i < 3; i++) rxb(dat(3, 1, i), 0);
    ck = csum(1, 8'h42, 3, 3);
    rxb(ck ^ 8'h01, 0);
    chkIrq("R5 mismatch irq", 3);
    chk(errChecksum, "R5 checksum flag", errChecksum, 1);
    idle();

    // R1: parity bad, R3: setting rejected after it
    header(8'h11, 0);
    chkIrq("R1 parity fail no irq", 0);
    chk(!errChecksum, "R1 flags cleared by header", errChecksum, 0);
    setup(2, 0, 0);
    chk(errMisuse, "R1 R3 setting rejected without header", errMisuse, 1);

    // R3: second setting in a frame does not restart the count
    header(8'h20, 1);
    chk(!errMisuse, "R1 misuse cleared", errMisuse, 0);
    setup(2, 0, 0);
    rxb(dat(2, 0, 0), 0);
    setup(5, 1, 1);
    chk(errMisuse && !txReq, "R3 second setting flagged", errMisuse, 1);
    rxb(dat(2, 0, 1), 0);
    rxb(csum(0, 8'h20, 2, 2), 0);
    chkIrq("R3 count kept", 2);
    idle();

    // R3: bad length rejected, valid one accepted afterwards
    header(8'h21, 1);
    setup(0, 0, 0);
    chk(errMisuse, "R3 zero length misuse", errMisuse, 1);
    setup(9, 0, 0);
    setup(1, 0, 0);
    rxb(dat(1, 0, 0), 0);
    rxb(csum(0, 8'h21, 1, 1), 0);
    chkIrq("R3 R2 valid setting after bad one", 2);
    idle();

    // R8: abort outside transmission
    pulseAbort();
    chk(!abortPend, "R8 abort in idle reads 0", abortPend, 0);
    header(8'h30, 1);
    pulseAbort();
    chk(!abortPend, "R8 abort in header state reads 0", abortPend, 0);

    // R7: abort during transmission
    for (int i = 0; i < 4; i++) swWrite(i, dat(4, 0, i));
    header(8'h31, 1);
    setup(4, 0, 1);
    txd(0);
    pulseAbort();
    chk(abortPend, "R7 abort held", abortPend, 1);
    chk(txReq && txByte == dat(4, 0, 1), "R7 current byte kept", txByte, dat(4, 0, 1));
    txd(0);
    chkIrq("R7 aborted irq", 4);
    chk(!abortPend && !txReq, "R7 abort self clears and stops", abortPend, 0);
    idle();

    // R9 R10: ignore frame
    header(8'h50, 1);
    chkIrq("R9 id irq before ignore", 1);
    pulseIgnore();
    chk(ignorePend, "R9 ignore set", ignorePend, 1);
    setup(3, 0, 0);
    for (int i = 0; i < 3; i++) begin
      rxb(8'hA0 + 8'(i), 0);
      chkIrq("R9 silent data", 0);
    end
    rxb(8'h00, 0);
    chkIrq("R9 silent checksum error", 0);
    chk(errChecksum, "R10 checksum flag in ignored frame", errChecksum, 1);
    for (int i = 0; i < 3; i++) readChk(i, 8'hA0 + 8'(i), "R10 buffer overwritten");
    idle();
    chk(!ignorePend, "R9 ignore clears on idle", ignorePend, 0);
    header(8'h51, 1);
    chkIrq("R9 irq back after header", 1);

    // R11: framing error
    setup(2, 0, 0);
    rxb(8'h33, 1);
    chkIrq("R11 framing irq", 3);
    chk(errFrame, "R11 framing flag", errFrame, 1);
    idle();

    // R11: bit error
    header(8'h52, 1);
    setup(2, 0, 1);
    txd(1);
    chkIrq("R11 bit error irq", 3);
    chk(errBit && !txReq, "R11 bit flag", errBit, 1);
    idle();

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule